// File: doc/BRIEF.md
# Hundredths-Resolution Calendar Timekeeper

This block is the counting core of a real-time clock. A one-cycle enable arriving at 32,768 Hz drives a fractional accumulator that produces exactly one hundred sub-second steps per second. Those steps advance a BCD calendar that holds hundredths, seconds, minutes, hours, weekday, date, month and two-digit year. The calendar shortens months with fewer than 31 days and gives February a 29th day in leap years.

The hour counter runs in either 24-hour or 12-hour form, and the 12-hour form carries a PM flag. Two alarms compare enabled fields of the current time, down to the hundredths. A match sets a sticky flag, and any set flag drives the interrupt line.

Software reaches the block through a byte-wide register port. Writes to time fields take effect at once. Reads have one cycle of latency, and a read of the hundredths register freezes a copy of the other time fields. Every field can then be read back as one consistent time.

Top module: `cal_timekeeper`

## Requirements
- R1: After reset the time reads 00:00:00.00 in 24-hour form, weekday 1, date 01, month 01, year 00. Both alarm flags are clear, irq_o is low and rdata_o is 00.
- R2: Each tick adds 100 to an accumulator. When the sum reaches TICK_HZ, the hundredths advance by one and TICK_HZ is subtracted. TICK_HZ ticks after a clear therefore give exactly 100 steps. Without a tick or a write, the hundredths do not change.
- R3: All fields hold BCD. Hundredths wrap from 99 to 00 and carry into seconds. Seconds and minutes wrap from 59 to 00 and carry onward. The weekday (1..7, in bits 3:0) moves from 7 to 1 on each day change.
- R4: The date wraps to 01 after day 30 in April, June, September and November, and after day 31 in the other long months. In February it wraps after day 28, or after day 29 when the binary year value is a multiple of 4.
- R5: In 24-hour form the hour register holds the BCD hour 00..23 in bits 5:0 with bit 6 clear. 23 advances to 00 and starts a new day.
- R6: In 12-hour form bit 6 of the hour register is 1, bit 5 is the PM flag, and bits 4:0 hold the BCD hour 12, 01..11. Going from 11 to 12 toggles PM. Going from 11 PM to 12 AM starts a new day.
- R7: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00.
- R8: The time registers are at addresses 0 to 7: 0 hundredths, 1 seconds, 2 minutes, 3 hour, 4 weekday, 5 date, 6 month, 7 year. A write loads the field at the next edge and clears the accumulator, so the next step comes ceil(TICK_HZ/100) ticks later.
- R9: Alarm n has its registers at 8+8n. Offsets 0..6 hold the compare values in the same field order as the time registers, and offset 7 is a mask whose bit i enables field i. The flag of alarm n sets when the time has just stepped and every enabled field matches. The flag stays set until a write to address 24 carries 1 in bit n; a 0 in that bit has no effect. Address 24 reads the flags in bits n. irq_o is high while any flag is set.
- R10: An alarm whose mask is zero never sets its flag.
- R11: rdata_o updates at the edge where rd_en_i is high. A read of address 0 returns the live hundredths and captures all time fields. Reads of addresses 1..7 return that captured copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle timebase enable at TICK_HZ |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| alarm_flag_o | output | NUM_ALARMS | Sticky alarm flags |
| irq_o | output | 1 | High while any alarm flag is set |

## Verification
The range assertions assume that software writes only legal BCD values: minutes and seconds up to 59, a weekday of 1 to 7, and an hour that fits the mode bit written with it. The date check applies only after a cycle without a write, because a date can be briefly out of range while month and date are loaded one at a time. The stimulus writes only valid values and loads year, month and date before the other fields. It raises tick_i and the register strobes in separate cycles. It runs the block with a small TICK_HZ so that whole-day and whole-year rollovers fit in short runs.

// File: rtl/cal_pkg.sv
package cal_pkg;

  typedef struct packed {
    logic [7:0] hsec;
    logic [7:0] sec;
    logic [7:0] min;
    logic       mode12;
    logic       pm;
    logic [5:0] hour;
    logic [3:0] wday;
    logic [7:0] date;
    logic [7:0] month;
    logic [7:0] year;
  } cal_time_t;

  localparam cal_time_t CAL_RESET = '{hsec: 8'h00, sec: 8'h00, min: 8'h00,
                                      mode12: 1'b0, pm: 1'b0, hour: 6'h00,
                                      wday: 4'd1, date: 8'h01, month: 8'h01,
                                      year: 8'h00};

  // two-digit BCD increment without wrap handling
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // last valid date (BCD) of a month, leap rule: binary year divisible by 4
  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
    logic [7:0] ybin;
    ybin = 8'(yr[7:4]) * 8'd10 + 8'(yr[3:0]);
    case (mon)
      8'h02:                      return ((ybin % 8'd4) == 8'd0) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  // register view of one time field
  function automatic logic [7:0] field_view(input cal_time_t t, input logic [2:0] sel);
    case (sel)
      3'd0:    return t.hsec;
      3'd1:    return t.sec;
      3'd2:    return t.min;
      3'd3:    return t.mode12 ? {1'b0, 1'b1, t.pm, t.hour[4:0]} : {2'b00, t.hour};
      3'd4:    return {4'h0, t.wday};
      3'd5:    return t.date;
      3'd6:    return t.month;
      default: return t.year;
    endcase
  endfunction

endpackage

// File: rtl/cal_rst_sync.sv
module cal_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/cal_subsec.sv
module cal_subsec #(
  parameter int TICK_HZ     = 32768,
  parameter int SUB_PER_SEC = 100,
  parameter int ACC_W       = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             clear_i,
  output logic             pulse_o,
  output logic [ACC_W-1:0] acc_o
);
  localparam logic [ACC_W:0] LIMIT = (ACC_W+1)'(TICK_HZ);
  localparam logic [ACC_W:0] STEP  = (ACC_W+1)'(SUB_PER_SEC);

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W:0]   sum;

  always_comb begin
    sum     = {1'b0, acc_q} + STEP;
    pulse_o = 1'b0;
    acc_d   = acc_q;
    if (clear_i) begin
      acc_d = '0;
    end else if (tick_i) begin
      if (sum >= LIMIT) begin
        pulse_o = 1'b1;
        acc_d   = ACC_W'(sum - LIMIT);
      end else begin
        acc_d   = ACC_W'(sum);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/cal_counter.sv
module cal_counter
  import cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step_i,
  input  logic       wr_i,
  input  logic [2:0] sel_i,
  input  logic [7:0] wdata_i,
  output cal_time_t  time_o
);
  cal_time_t cur_q, nxt;
  logic c_sec, c_min, c_hr, c_day, c_mon, c_yr;

  always_comb begin
    c_sec = step_i && (cur_q.hsec == 8'h99);
    c_min = c_sec && (cur_q.sec == 8'h59);
    c_hr  = c_min && (cur_q.min == 8'h59);
    c_day = c_hr && (cur_q.mode12 ? (cur_q.pm && cur_q.hour == 6'h11)
                                  : (cur_q.hour == 6'h23));
    c_mon = c_day && (cur_q.date == month_len(cur_q.month, cur_q.year));
    c_yr  = c_mon && (cur_q.month == 8'h12);

    nxt = cur_q;
    if (wr_i) begin
      case (sel_i)
        3'd0: nxt.hsec = wdata_i;
        3'd1: nxt.sec  = wdata_i;
        3'd2: nxt.min  = wdata_i;
        3'd3: begin
          nxt.mode12 = wdata_i[6];
          nxt.pm     = wdata_i[6] & wdata_i[5];
          nxt.hour   = wdata_i[6] ? {1'b0, wdata_i[4:0]} : wdata_i[5:0];
        end
        3'd4: nxt.wday  = wdata_i[3:0];
        3'd5: nxt.date  = wdata_i;
        3'd6: nxt.month = wdata_i;
        default: nxt.year = wdata_i;
      endcase
    end else if (step_i) begin
      nxt.hsec = c_sec ? 8'h00 : bcd_inc(cur_q.hsec);
      if (c_sec) nxt.sec = c_min ? 8'h00 : bcd_inc(cur_q.sec);
      if (c_min) nxt.min = c_hr ? 8'h00 : bcd_inc(cur_q.min);
      if (c_hr) begin
        if (!cur_q.mode12) begin
          nxt.hour = (cur_q.hour == 6'h23) ? 6'h00 : 6'(bcd_inc({2'b00, cur_q.hour}));
        end else if (cur_q.hour == 6'h12) begin
          nxt.hour = 6'h01;
        end else begin
          nxt.hour = 6'(bcd_inc({2'b00, cur_q.hour}));
          if (cur_q.hour == 6'h11) nxt.pm = ~cur_q.pm;
        end
      end
      if (c_day) begin
        nxt.wday = (cur_q.wday == 4'd7) ? 4'd1 : cur_q.wday + 4'd1;
        nxt.date = c_mon ? 8'h01 : bcd_inc(cur_q.date);
      end
      if (c_mon) nxt.month = c_yr ? 8'h01 : bcd_inc(cur_q.month);
      if (c_yr)  nxt.year  = (cur_q.year == 8'h99) ? 8'h00 : bcd_inc(cur_q.year);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= CAL_RESET;
    else        cur_q <= nxt;
  end

  assign time_o = cur_q;
endmodule

// File: rtl/cal_alarm.sv
module cal_alarm
  import cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  cal_time_t  time_i,
  input  logic       wr_i,
  input  logic [2:0] sel_i,
  input  logic [7:0] wdata_i,
  input  logic       clr_i,
  input  logic       eval_i,
  output logic [7:0] rd_o,
  output logic       flag_o
);
  localparam int FIELDS = 7;

  logic [7:0]        cfg_q [8];
  logic [7:0]        cfg_d [8];
  logic [FIELDS-1:0] eq;
  logic              hit, flag_q, flag_d;

  for (genvar gi = 0; gi < FIELDS; gi++) begin : g_cmp
    assign eq[gi] = !cfg_q[7][gi] || (cfg_q[gi] == field_view(time_i, 3'(gi)));
  end

  always_comb begin
    hit = (&eq) && (|cfg_q[7][FIELDS-1:0]);
    for (int i = 0; i < 8; i++) cfg_d[i] = cfg_q[i];
    if (wr_i) cfg_d[sel_i] = wdata_i;
    flag_d = flag_q;
    if (clr_i)         flag_d = 1'b0;
    if (eval_i && hit) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) cfg_q[i] <= 8'h00;
      flag_q <= 1'b0;
    end else begin
      for (int i = 0; i < 8; i++) cfg_q[i] <= cfg_d[i];
      flag_q <= flag_d;
    end
  end

  assign rd_o   = cfg_q[sel_i];
  assign flag_o = flag_q;
endmodule

// File: rtl/cal_timekeeper.sv
module cal_timekeeper #(
  parameter int TICK_HZ     = 32768,
  parameter int SUB_PER_SEC = 100,
  parameter int NUM_ALARMS  = 2,
  parameter int ADDR_W      = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_i,
  input  logic                  wr_en_i,
  input  logic                  rd_en_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [7:0]            wdata_i,
  output logic [7:0]            rdata_o,
  output logic [NUM_ALARMS-1:0] alarm_flag_o,
  output logic                  irq_o
);
  import cal_pkg::*;

  localparam int              ACC_W     = $clog2(TICK_HZ);
  localparam int              BANK_W    = ADDR_W - 3;
  localparam logic [ADDR_W-1:0] ADR_FLAGS = ADDR_W'(8 * (NUM_ALARMS + 1));

  logic              rst_sync_n;
  logic              time_wr, flags_wr, snap, hsec_step, step_q;
  logic [ACC_W-1:0]  acc_q;
  logic [BANK_W-1:0] bank;
  logic [7:0]        rd_d;
  logic [7:0]        alm_rd [NUM_ALARMS];
  cal_time_t         time_q, shadow_q;

  assign bank     = addr_i[ADDR_W-1:3];
  assign time_wr  = wr_en_i && (bank == '0);
  assign flags_wr = wr_en_i && (addr_i == ADR_FLAGS);
  assign snap     = rd_en_i && (addr_i == '0);

  cal_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cal_subsec #(
    .TICK_HZ     (TICK_HZ),
    .SUB_PER_SEC (SUB_PER_SEC),
    .ACC_W       (ACC_W)
  ) u_sub (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick_i  (tick_i),
    .clear_i (time_wr),
    .pulse_o (hsec_step),
    .acc_o   (acc_q)
  );

  cal_counter u_cnt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .step_i  (hsec_step),
    .wr_i    (time_wr),
    .sel_i   (addr_i[2:0]),
    .wdata_i (wdata_i),
    .time_o  (time_q)
  );

  for (genvar n = 0; n < NUM_ALARMS; n++) begin : g_alarm
    cal_alarm u_alm (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .time_i  (time_q),
      .wr_i    (wr_en_i && (bank == BANK_W'(n + 1))),
      .sel_i   (addr_i[2:0]),
      .wdata_i (wdata_i),
      .clr_i   (flags_wr && wdata_i[n]),
      .eval_i  (step_q),
      .rd_o    (alm_rd[n]),
      .flag_o  (alarm_flag_o[n])
    );
  end

  always_comb begin
    rd_d = 8'h00;
    if (bank == '0) begin
      rd_d = (addr_i[2:0] == 3'd0) ? time_q.hsec : field_view(shadow_q, addr_i[2:0]);
    end else if (addr_i == ADR_FLAGS) begin
      rd_d = 8'(alarm_flag_o);
    end else begin
      for (int n = 0; n < NUM_ALARMS; n++) begin
        if (bank == BANK_W'(n + 1)) rd_d = alm_rd[n];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rdata_o  <= 8'h00;
      step_q   <= 1'b0;
      shadow_q <= CAL_RESET;
    end else begin
      step_q <= hsec_step;
      if (rd_en_i) rdata_o  <= rd_d;
      if (snap)    shadow_q <= time_q;
    end
  end

  assign irq_o = |alarm_flag_o;
endmodule

// File: rtl/cal_timekeeper_chk.sv
module cal_timekeeper_chk
  import cal_pkg::*;
#(
  parameter int TICK_HZ    = 32768,
  parameter int NUM_ALARMS = 2,
  parameter int ADDR_W     = 5,
  parameter int ACC_W      = 15
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  tick_i,
  input logic                  wr_en_i,
  input logic [ADDR_W-1:0]     addr_i,
  input logic [NUM_ALARMS-1:0] clr_bits,
  input cal_time_t             t,
  input logic [ACC_W-1:0]      acc,
  input logic [NUM_ALARMS-1:0] flags
);
  localparam logic [ADDR_W-1:0] ADR_FLAGS = ADDR_W'(8 * (NUM_ALARMS + 1));

  function automatic logic date_ok(input cal_time_t x);
    return (x.date != 8'h00) && (x.date <= month_len(x.month, x.year));
  endfunction

  AST_ACC_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    int'(acc) < TICK_HZ);                                                         // R2
  AST_HSEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !wr_en_i) |=> $stable(t.hsec));                                   // R2
  AST_TIME_BCD: assert property (@(posedge clk) disable iff (!rst_n)
    (t.hsec[3:0] <= 4'd9 && t.hsec[7:4] <= 4'd9 && t.sec[3:0] <= 4'd9 &&
     t.sec <= 8'h59 && t.min[3:0] <= 4'd9 && t.min <= 8'h59));                    // R3
  AST_WDAY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (t.wday >= 4'd1 && t.wday <= 4'd7));                                          // R3
  AST_DATE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && date_ok(t)) |=> date_ok(t));                                     // R4
  AST_HOUR12_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    t.mode12 |-> (t.hour >= 6'h01 && t.hour <= 6'h12));                           // R6
  AST_PM_ONLY_12H: assert property (@(posedge clk) disable iff (!rst_n)
    !t.mode12 |-> !t.pm);                                                         // R6

  for (genvar n = 0; n < NUM_ALARMS; n++) begin : g_flag
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[n] && !(wr_en_i && addr_i == ADR_FLAGS && clr_bits[n])) |=> flags[n]); // R9
  end
endmodule

bind cal_timekeeper cal_timekeeper_chk #(
  .TICK_HZ    (TICK_HZ),
  .NUM_ALARMS (NUM_ALARMS),
  .ADDR_W     (ADDR_W),
  .ACC_W      (ACC_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .tick_i   (tick_i),
  .wr_en_i  (wr_en_i),
  .addr_i   (addr_i),
  .clr_bits (wdata_i[NUM_ALARMS-1:0]),
  .t        (time_q),
  .acc      (acc_q),
  .flags    (alarm_flag_o)
);

// File: tb/cal_timekeeper_tb_top.sv
`timescale 1ns/1ps
module cal_timekeeper_tb_top;
  localparam int TICK_HZ = 128;
  localparam int NA      = 2;

  logic clk = 1'b0, rst_n = 1'b0, tick_i = 1'b0, wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [4:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [NA-1:0] alarm_flag_o;
  logic irq_o;

  int checks = 0, failures = 0;
  int m_acc, m_h, m_s, m_m, m_hr, m_wd, m_dt, m_mo, m_yr, m_m12;
  logic [7:0] a_cfg [NA][8];
  logic [NA-1:0] m_flag;

  always #2 clk = ~clk;

  cal_timekeeper #(.TICK_HZ(TICK_HZ), .SUB_PER_SEC(100), .NUM_ALARMS(NA), .ADDR_W(5)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .alarm_flag_o(alarm_flag_o), .irq_o(irq_o));

  function automatic int mdays(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] tobcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [7:0] mview(int sel);
    logic [7:0] b;
    int h12;
    case (sel)
      0: return tobcd(m_h);
      1: return tobcd(m_s);
      2: return tobcd(m_m);
      3: begin
        if (m_m12 == 0) return tobcd(m_hr);
        h12 = (m_hr % 12 == 0) ? 12 : m_hr % 12;
        b = tobcd(h12);
        return {1'b0, 1'b1, (m_hr >= 12), b[4:0]};
      end
      4: return tobcd(m_wd);
      5: return tobcd(m_dt);
      6: return tobcd(m_mo);
      default: return tobcd(m_yr);
    endcase
  endfunction

  task automatic model_step();
    logic hit;
    m_h++;
    if (m_h == 100) begin
      m_h = 0; m_s++;
      if (m_s == 60) begin
        m_s = 0; m_m++;
        if (m_m == 60) begin
          m_m = 0; m_hr++;
          if (m_hr == 24) begin
            m_hr = 0;
            m_wd = (m_wd == 7) ? 1 : m_wd + 1;
            m_dt++;
            if (m_dt > mdays(m_mo, m_yr)) begin
              m_dt = 1; m_mo++;
              if (m_mo == 13) begin m_mo = 1; m_yr = (m_yr + 1) % 100; end
            end
          end
        end
      end
    end
    for (int n = 0; n < NA; n++) begin
      hit = (a_cfg[n][7][6:0] != 7'd0);
      for (int i = 0; i < 7; i++)
        if (a_cfg[n][7][i] && a_cfg[n][i] != mview(i)) hit = 1'b0;
      if (hit) m_flag[n] = 1'b1;
    end
  endtask

  task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = 5'(a); wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
    if (a < 8) m_acc = 0;
    if (a >= 8 && a < 8 * (NA + 1)) a_cfg[a / 8 - 1][a % 8] = d;
    if (a == 8 * (NA + 1)) m_flag = m_flag & ~d[NA-1:0];
  endtask

  task automatic rd(int a, output logic [7:0] v);
    @(negedge clk);
    rd_en_i = 1'b1; addr_i = 5'(a);
    @(negedge clk);
    rd_en_i = 1'b0;
    v = rdata_o;
  endtask

  task automatic ticks(int n);
    @(negedge clk);
    tick_i = 1'b1;
    for (int k = 0; k < n; k++) begin
      m_acc += 100;
      if (m_acc >= TICK_HZ) begin m_acc -= TICK_HZ; model_step(); end
      @(negedge clk);
    end
    tick_i = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic set_time(int hr, int mi, int s, int h, int wd, int dt, int mo, int yr, int m12);
    m_hr = hr; m_m = mi; m_s = s; m_h = h; m_wd = wd; m_dt = dt; m_mo = mo; m_yr = yr; m_m12 = m12;
    for (int i = 7; i >= 0; i--) wr(i, mview(i));
  endtask

  task automatic chk_all(string tag);
    logic [7:0] v;
    rd(0, v);
    chk(tag, "hsec", v, mview(0));
    for (int i = 1; i < 8; i++) begin
      rd(i, v);
      chk(tag, $sformatf("field%0d", i), v, mview(i));
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v, snap_sec;
    m_flag = '0;
    for (int n = 0; n < NA; n++) for (int i = 0; i < 8; i++) a_cfg[n][i] = 8'h00;
    m_acc = 0; m_h = 0; m_s = 0; m_m = 0; m_hr = 0; m_wd = 1; m_dt = 1; m_mo = 1; m_yr = 0; m_m12 = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1", "rdata", rdata_o, 8'h00);
    chk("R1", "irq", {7'd0, irq_o}, 8'h00);
    chk_all("R1");
    rd(24, v);
    chk("R1", "flags", v, 8'h00);

    // R2: one full second of ticks, then a partial run
    ticks(TICK_HZ);
    rd(0, v);
    chk("R2", "hsec after 1s", v, 8'h00);
    rd(1, v);
    chk("R2", "sec after 1s", v, 8'h01);
    ticks(37);
    rd(0, v);
    chk("R2", "hsec after 37 ticks", v, tobcd((37 * 100) / TICK_HZ));

    // R8: a write clears the accumulator (one tick then gives no step)
    wr(1, 8'h30); m_s = 30;
    ticks(1);
    chk_all("R8");
    ticks(1);
    chk_all("R8");

    // R3: carry chain through seconds and minutes
    set_time(10, 58, 59, 99, 3, 10, 5, 20, 0);
    ticks(2);
    chk_all("R3");

    // R4/R7: last and second-to-last day of every month over several years
    foreach (v[i]) ; // no-op placeholder loop avoided
    for (int yi = 0; yi < 5; yi++) begin
      for (int mo = 1; mo <= 12; mo++) begin
        for (int off = 0; off < 2; off++) begin
          int yr;
          yr = (yi == 4) ? 99 : yi;
          set_time(23, 59, 59, 99, 7, mdays(mo, yr) - off, mo, yr, 0);
          ticks(2);
          chk_all((mo == 12 && off == 0) ? "R7" : "R4");
        end
      end
    end

    // R5: every hour boundary in 24-hour form
    for (int hr = 0; hr < 24; hr++) begin
      set_time(hr, 59, 59, 99, 2, 15, 6, 10, 0);
      ticks(2);
      chk_all("R5");
    end

    // R6: every hour boundary in 12-hour form
    for (int hr = 0; hr < 24; hr++) begin
      set_time(hr, 59, 59, 99, 7, 31, 12, 99, 1);
      ticks(2);
      chk_all("R6");
    end

    // R9/R10: alarms
    set_time(0, 0, 0, 0, 1, 1, 1, 0, 0);
    wr(8 + 0, 8'h05); wr(8 + 1, 8'h00); wr(8 + 2, 8'h33); wr(8 + 7, 8'h03);
    wr(16 + 0, 8'h03); wr(16 + 1, 8'h00); wr(16 + 7, 8'h00);
    ticks(12);
    rd(24, v);
    chk("R9", "flags after match", v, 8'(m_flag));
    chk("R9", "flags expected set", v, 8'h01);
    chk("R9", "irq", {7'd0, irq_o}, 8'h01);
    chk("R10", "masked-off alarm flag", {7'd0, alarm_flag_o[1]}, 8'h00);
    wr(24, 8'h00);
    rd(24, v);
    chk("R9", "write 0 keeps flag", v, 8'h01);
    wr(24, 8'h01);
    rd(24, v);
    chk("R9", "write 1 clears flag", v, 8'h00);
    chk("R9", "irq after clear", {7'd0, irq_o}, 8'h00);
    ticks(12);
    rd(24, v);
    chk("R9", "no rematch", v, 8'(m_flag));
    rd(8 + 2, v);
    chk("R9", "alarm readback", v, 8'h33);
    wr(16 + 0, 8'h20); wr(16 + 7, 8'h01);
    ticks(8);
    rd(24, v);
    chk("R9", "alarm1 hsec match", v, 8'(m_flag));
    chk("R9", "alarm1 port flag", 8'(alarm_flag_o), 8'(m_flag));

    // R11: coherent read through the captured copy
    set_time(10, 20, 30, 0, 4, 12, 3, 21, 0);
    ticks(2);
    rd(0, v);
    chk("R11", "live hsec", v, mview(0));
    snap_sec = mview(1);
    ticks(TICK_HZ);
    rd(1, v);
    chk("R11", "sec from capture", v, snap_sec);
    rd(0, v);
    rd(1, v);
    chk("R11", "sec after new capture", v, mview(1));
    chk("R11", "sec advanced", v, 8'h31);

    finish_run();
  end
endmodule